// File: doc/BRIEF.md
# I2C Master Transmit Shifter with Programmable Frame Length

This block is the transmit half of an I2C master. Software writes a byte to a holding register. When the engine is idle and that register holds unsent data, the engine moves the byte into a shift register. It then clocks the byte out on SDA, MSB first, using an SCL generated by an internal divider, and finishes every frame with one acknowledge clock. During the acknowledge clock SDA is released and the receiver's answer is sampled.

Frame length is set by a 3-bit code in the control register. The code covers the data bits and the acknowledge bit together, so code 0 gives a full 9-clock frame (8 data bits plus acknowledge). Codes 1 to 7 give frames of 2 to 8 clocks. Once a frame ends, the code falls back to 0 by itself.

Two interrupt requests come from the status flags:
- The holding-register-empty request tells software it may write the next byte.
- The transmit-end request marks a frame whose final clock rose while no further byte was waiting.

The module does not generate start or stop conditions. Between frames it holds SCL low.

Top module: `i2c_tx_engine`

## Requirements
- R1: After reset the bit-count code and both interrupt enables are 0, the empty flag is 1, the end flag is 0, both requests are low, and sclOut and sdaOut are 1.
- R2: txiReq is 1 exactly when the empty flag is 1 and the empty-interrupt enable (control bit 4) is 1.
- R3: A write to address 1 (data) clears the empty flag. The flag is set again when an idle engine moves the pending byte into the shift register and begins a frame.
- R4: A frame is N SCL clocks: the N-1 most significant bits of the byte, MSB first, then one acknowledge clock. N is 9 for code 0 and code+1 for codes 1 to 7 (control bits 2:0).
- R5: SDA changes only while SCL is low. Each SCL high phase lasts HALF_DIV clock cycles.
- R6: During the acknowledge clock sdaOut is released to 1. sdaIn is sampled on that clock's rising SCL edge into ackBit, where 0 means acknowledged.
- R7: On the rising SCL edge of a frame's last clock, the end flag is set if the empty flag is 1. If a new byte is already waiting, the flag is left unchanged.
- R8: teiReq is 1 exactly when the end flag and the end-interrupt enable (control bit 5) are both 1. It drops when either one is cleared. Writing address 2 with bit 0 set clears the end flag.
- R9: The bit-count code returns to 0 when a frame ends, after the acknowledge clock.
- R10: A write of a nonzero code through address 0 only takes effect while the engine is idle and sclIn is low. Otherwise the code field keeps its value, while the enable bits of the same write still take effect. A zero code is always accepted.
- R11: After a frame ends, SCL stays low until the next frame begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address: 0 control, 1 data, 2 status clear |
| wrData | input | 8 | Register write data |
| sclIn | input | 1 | Sensed SCL line level |
| sdaIn | input | 1 | Sensed SDA line level |
| sclOut | output | 1 | SCL drive (1 = released) |
| sdaOut | output | 1 | SDA drive (1 = released) |
| txiReq | output | 1 | Holding-register-empty interrupt request |
| teiReq | output | 1 | Transmit-end interrupt request |
| tdreFlag | output | 1 | Holding register empty flag |
| tendFlag | output | 1 | Transmit end flag |
| ackBit | output | 1 | Last sampled acknowledge (0 = ACK) |
| bitCode | output | 3 | Current bit-count code |
| busy | output | 1 | Frame in progress |

## Verification
The assertions check these rules on every cycle:
- SDA only moves while SCL is low.
- A request is never raised without its flag.
- The end flag rises only together with a rising SCL inside a frame.
- A frame always starts with the empty flag set.
- The code is back at 0 and SCL is low whenever a frame ends.
- The code never moves to a new nonzero value during a frame.

Only the bench scenarios can show the following:
- The bit sequence on the wire for each frame length.
- The acknowledge level captured for both ACK and NACK.
- The end flag staying clear when a back-to-back byte was already queued.
- The ignored code writes, seen both with SCL high and during a frame.

// File: rtl/i2c_tx_pkg.sv
package i2c_tx_pkg;
  localparam int DATA_W = 8;
  localparam int CODE_W = 3;
  localparam int CNT_W  = 4;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

  localparam int CTRL_TXIE_BIT = 4;
  localparam int CTRL_TEIE_BIT = 5;

  typedef struct packed {
    logic loadShift;
    logic shiftNext;
    logic sampleAck;
    logic frameDone;
  } txStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} txState_t;

  function automatic logic [CNT_W-1:0] frameLen(input logic [CODE_W-1:0] code);
    if (code == '0) return CNT_W'(9);
    return CNT_W'(code) + CNT_W'(1);
  endfunction
endpackage

// File: rtl/i2c_tx_ctrl.sv
module i2c_tx_ctrl
  import i2c_tx_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tdreFlag,
  input  logic [CODE_W-1:0] bitCode,
  output txStrobe_t         strobe,
  output logic              sclOut,
  output logic              busy,
  output logic              ackPhase
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  txState_t         state;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitIdx;
  logic [CNT_W-1:0] lenReg;
  logic             sclReg;
  logic             phaseEnd;
  logic             lastBit;

  assign phaseEnd = (divCnt == DIV_LAST);
  assign lastBit  = (bitIdx == lenReg - CNT_W'(1));
  assign busy     = (state != ST_IDLE);
  assign ackPhase = busy && lastBit;
  assign sclOut   = sclReg;

  always_comb begin
    strobe = '0;
    unique case (state)
      ST_IDLE: strobe.loadShift = !tdreFlag;
      ST_LOW:  strobe.sampleAck = phaseEnd && lastBit;
      ST_HIGH: begin
        strobe.frameDone = phaseEnd && lastBit;
        strobe.shiftNext = phaseEnd && !lastBit;
      end
      default: strobe = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      divCnt <= '0;
      bitIdx <= '0;
      lenReg <= CNT_W'(9);
      sclReg <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (!tdreFlag) begin
            lenReg <= frameLen(bitCode);
            bitIdx <= '0;
            divCnt <= '0;
            sclReg <= 1'b0;
            state  <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (phaseEnd) begin
            divCnt <= '0;
            sclReg <= 1'b1;
            state  <= ST_HIGH;
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        ST_HIGH: begin
          if (phaseEnd) begin
            divCnt <= '0;
            sclReg <= 1'b0;
            if (lastBit) begin
              state <= ST_IDLE;
            end else begin
              bitIdx <= bitIdx + CNT_W'(1);
              state  <= ST_LOW;
            end
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_tx_datapath.sv
module i2c_tx_datapath
  import i2c_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  txStrobe_t         strobe,
  input  logic              busy,
  input  logic              ackPhase,
  output logic              sdaOut,
  output logic              tdreFlag,
  output logic              tendFlag,
  output logic              ackBit,
  output logic [CODE_W-1:0] bitCode,
  output logic              txIntEn,
  output logic              tendIntEn
);
  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] shiftReg;
  logic              ctrlWr;
  logic              dataWr;
  logic              statWr;
  logic              codeOk;

  assign ctrlWr = wrEn && (wrAddr == ADDR_CTRL);
  assign dataWr = wrEn && (wrAddr == ADDR_DATA);
  assign statWr = wrEn && (wrAddr == ADDR_STAT);
  assign codeOk = (wrData[CODE_W-1:0] == '0) || (!busy && !sclIn);

  assign sdaOut = !busy || ackPhase || shiftReg[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txIntEn   <= 1'b0;
      tendIntEn <= 1'b0;
      bitCode   <= '0;
    end else begin
      if (strobe.frameDone) bitCode <= '0;
      if (ctrlWr) begin
        txIntEn   <= wrData[CTRL_TXIE_BIT];
        tendIntEn <= wrData[CTRL_TEIE_BIT];
        if (codeOk) bitCode <= wrData[CODE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg  <= '0;
      shiftReg <= '0;
      tdreFlag <= 1'b1;
    end else begin
      if (strobe.loadShift) begin
        shiftReg <= dataReg;
        tdreFlag <= 1'b1;
      end else if (strobe.shiftNext) begin
        shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
      end
      if (dataWr) begin
        dataReg  <= wrData;
        tdreFlag <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tendFlag <= 1'b0;
      ackBit   <= 1'b0;
    end else begin
      if (strobe.sampleAck) begin
        ackBit <= sdaIn;
        if (tdreFlag) tendFlag <= 1'b1;
      end
      if (statWr && wrData[0]) tendFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_tx_engine.sv
module i2c_tx_engine
  import i2c_tx_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic [7:0]  wrData,
  input  logic        sclIn,
  input  logic        sdaIn,
  output logic        sclOut,
  output logic        sdaOut,
  output logic        txiReq,
  output logic        teiReq,
  output logic        tdreFlag,
  output logic        tendFlag,
  output logic        ackBit,
  output logic [2:0]  bitCode,
  output logic        busy
);
  txStrobe_t strobe;
  logic      ackPhase;
  logic      txIntEn;
  logic      tendIntEn;

  i2c_tx_ctrl #(.HALF_DIV(HALF_DIV)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tdreFlag (tdreFlag),
    .bitCode  (bitCode),
    .strobe   (strobe),
    .sclOut   (sclOut),
    .busy     (busy),
    .ackPhase (ackPhase)
  );

  i2c_tx_datapath i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .strobe    (strobe),
    .busy      (busy),
    .ackPhase  (ackPhase),
    .sdaOut    (sdaOut),
    .tdreFlag  (tdreFlag),
    .tendFlag  (tendFlag),
    .ackBit    (ackBit),
    .bitCode   (bitCode),
    .txIntEn   (txIntEn),
    .tendIntEn (tendIntEn)
  );

  assign txiReq = tdreFlag && txIntEn;
  assign teiReq = tendFlag && tendIntEn;
endmodule

// File: rtl/i2c_tx_checker.sv
module i2c_tx_checker (
  input logic       clk,
  input logic       rstN,
  input logic       sclOut,
  input logic       sdaOut,
  input logic       txiReq,
  input logic       teiReq,
  input logic       tdreFlag,
  input logic       tendFlag,
  input logic       busy,
  input logic [2:0] bitCode
);
  a_r2_txi_needs_empty: assert property (@(posedge clk) disable iff (!rstN)
    txiReq |-> tdreFlag);

  a_r8_tei_needs_end: assert property (@(posedge clk) disable iff (!rstN)
    teiReq |-> tendFlag);

  a_r5_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOut) |-> !sclOut);

  a_r7_end_on_scl_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tendFlag) |-> ($rose(sclOut) && busy));

  a_r3_start_sets_empty: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> tdreFlag);

  a_r9_code_back_to_zero: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (bitCode == 3'd0));

  a_r11_scl_held_low: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !sclOut);

  a_r10_code_locked_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> (bitCode == $past(bitCode) || bitCode == 3'd0));
endmodule

bind i2c_tx_engine i2c_tx_checker i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sclOut   (sclOut),
  .sdaOut   (sdaOut),
  .txiReq   (txiReq),
  .teiReq   (teiReq),
  .tdreFlag (tdreFlag),
  .tendFlag (tendFlag),
  .busy     (busy),
  .bitCode  (bitCode)
);

// File: tb/test_i2c_tx_engine.sv
module test_i2c_tx_engine;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int WATCHDOG = 50000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic       ackLow = 1'b0;
  logic       sclIn, sdaIn, sclOut, sdaOut, txiReq, teiReq;
  logic       tdreFlag, tendFlag, ackBit, busy;
  logic [2:0] bitCode;

  int nTests = 0;
  int nFail = 0;
  int cycles = 0;

  typedef struct {
    int         len;
    logic [7:0] data;
    logic       ack;
  } item_t;
  item_t expQ[$];

  assign sclIn = sclOut;
  assign sdaIn = sdaOut & ~ackLow;

  i2c_tx_engine #(.HALF_DIV(HALF)) i_i2c_tx_engine (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .sclIn(sclIn), .sdaIn(sdaIn), .sclOut(sclOut), .sdaOut(sdaOut),
    .txiReq(txiReq), .teiReq(teiReq), .tdreFlag(tdreFlag), .tendFlag(tendFlag),
    .ackBit(ackBit), .bitCode(bitCode), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wrAddr = a;
    wrData = d;
    wrEn   = 1'b1;
    @(negedge clk);
    wrEn   = 1'b0;
  endtask

  function automatic logic [7:0] ctrlByte(input bit teie, input bit txie, input int code);
    return {2'b00, teie, txie, 1'b0, 3'(code)};
  endfunction

  task automatic sendByte(input int len, input logic [7:0] d, input logic ack);
    item_t it;
    it.len = len;
    it.data = d;
    it.ack = ack;
    expQ.push_back(it);
    wr(2'd1, d);
  endtask

  task automatic waitFrameEnd();
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  // scoreboard monitor
  logic bitsSeen[16];
  int   nBits = 0;
  int   highCnt = 0;
  bit   tracking = 0;
  bit   highBad = 0;
  logic prevScl = 1'b1;
  logic prevBusy = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (busy && sclOut && !prevScl) begin
        if (nBits < 16) bitsSeen[nBits] = sdaOut;
        nBits++;
        highCnt = 1;
        tracking = 1;
      end else if (sclOut && tracking) begin
        highCnt++;
      end
      if (!sclOut && prevScl && tracking) begin
        if (highCnt != HALF) highBad = 1;
        tracking = 0;
      end
      if (prevBusy && !busy) begin
        if (expQ.size() == 0) begin
          chk(0, "R4 unexpected frame", 1, 0);
        end else begin
          item_t it;
          logic [7:0] got;
          logic [7:0] mask;
          it = expQ.pop_front();
          got = 8'h00;
          for (int i = 0; i < it.len - 1 && i < 8; i++) got[7-i] = bitsSeen[i];
          mask = 8'hFF << (9 - it.len);
          chk(nBits == it.len, "R4 frame length", nBits, it.len);
          chk(got == (it.data & mask), "R4 data bits MSB first", got, it.data & mask);
          chk(bitsSeen[it.len-1] == 1'b1, "R6 sda released on ack clock",
              bitsSeen[it.len-1], 1);
          chk(ackBit == it.ack, "R6 ack captured", ackBit, it.ack);
          chk(!highBad, "R5 scl high phase length", highBad, 0);
        end
        nBits = 0;
        highBad = 0;
      end
      prevScl = sclOut;
      prevBusy = busy;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(sclOut == 1 && sdaOut == 1, "R1 lines released", {sclOut, sdaOut}, 3);
    chk(tdreFlag == 1 && tendFlag == 0, "R1 flags", {tdreFlag, tendFlag}, 2);
    chk(bitCode == 0 && txiReq == 0 && teiReq == 0, "R1 code and requests",
        {bitCode, txiReq, teiReq}, 0);

    // R10 nonzero code ignored while SCL high; R2 enable raises request
    wr(2'd0, ctrlByte(0, 1, 3));
    chk(bitCode == 0, "R10 code write with scl high", bitCode, 0);
    chk(txiReq == 1, "R2 txi with empty flag", txiReq, 1);

    // Frame 1: 9 clocks, ACK
    ackLow = 1'b1;
    sendByte(9, 8'hA5, 1'b0);
    chk(tdreFlag == 0, "R3 data write clears empty", tdreFlag, 0);
    chk(txiReq == 0, "R2 txi drops", txiReq, 0);
    @(negedge clk);
    chk(tdreFlag == 1, "R3 frame start sets empty", tdreFlag, 1);
    waitFrameEnd();
    chk(tendFlag == 1, "R7 end flag after last clock", tendFlag, 1);
    chk(sclOut == 0, "R11 scl low after frame", sclOut, 0);
    chk(teiReq == 0, "R8 tei masked", teiReq, 0);
    repeat (5) @(negedge clk);
    chk(sclOut == 0, "R11 scl still low", sclOut, 0);

    // R8 enable and clear
    wr(2'd0, ctrlByte(1, 1, 0));
    chk(teiReq == 1, "R8 tei raised", teiReq, 1);
    wr(2'd2, 8'h01);
    chk(tendFlag == 0 && teiReq == 0, "R8 clear end flag", {tendFlag, teiReq}, 0);

    // Frame 2: code 4 -> 5 clocks, NACK
    wr(2'd0, ctrlByte(1, 1, 4));
    chk(bitCode == 4, "R10 code accepted idle scl low", bitCode, 4);
    ackLow = 1'b0;
    sendByte(5, 8'h3C, 1'b1);
    waitFrameEnd();
    chk(bitCode == 0, "R9 code reload", bitCode, 0);
    chk(teiReq == 1, "R8 tei after frame", teiReq, 1);
    wr(2'd0, ctrlByte(0, 1, 0));
    chk(teiReq == 0 && tendFlag == 1, "R8 tei dropped by enable", {teiReq, tendFlag}, 1);
    wr(2'd2, 8'h01);

    // Frames 3 and 4: back to back, code 7 then default
    ackLow = 1'b1;
    wr(2'd0, ctrlByte(0, 1, 7));
    sendByte(8, 8'h96, 1'b0);
    while (!busy) @(negedge clk);
    repeat (6) @(negedge clk);
    wr(2'd0, ctrlByte(0, 1, 2));
    chk(bitCode == 7, "R10 code write ignored in frame", bitCode, 7);
    sendByte(9, 8'h5A, 1'b0);
    chk(tdreFlag == 0, "R3 queued byte clears empty", tdreFlag, 0);
    while (busy) @(negedge clk);
    chk(tendFlag == 0, "R7 no end flag with byte waiting", tendFlag, 0);
    chk(bitCode == 0, "R9 code reload after 8-clock frame", bitCode, 0);
    waitFrameEnd();
    chk(tendFlag == 1, "R7 end flag after second frame", tendFlag, 1);

    // Frame 5: code 1 -> 2 clocks
    wr(2'd2, 8'h01);
    wr(2'd0, ctrlByte(0, 0, 1));
    chk(txiReq == 0, "R2 txi disabled", txiReq, 0);
    sendByte(2, 8'h80, 1'b0);
    waitFrameEnd();
    chk(tendFlag == 1, "R7 end flag short frame", tendFlag, 1);
    chk(bitCode == 0, "R9 code reload short frame", bitCode, 0);

    repeat (4) @(negedge clk);
    chk(expQ.size() == 0, "R4 all frames seen", expQ.size(), 0);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule